// File: doc/BRIEF.md
# Three-Phase Center-Aligned PWM Timing Unit

The block drives three complementary gate-signal pairs, one high side and one low side for each of phases A, B and C. One up/down sweep counter sets the timing for all three pairs. Each period has two halves of equal length. In the leading half the counter counts down towards the period centre, and in the trailing half it counts back up. Each phase compares its duty value against the counter's distance from the centre, so every pulse sits symmetrically around the midpoint.

A dead-time value moves each switching edge apart, so both switches of a pair are off for a while around every transition. A minimum-width value removes slivers: if a side's adjusted on-time in a half falls below it, that side stays off for the whole half and the other side stays on for the whole half.

A single-cycle sync pulse marks each period start. A single-cycle strobe marks the midpoint. Settings are picked up at the period start. In double-update mode the three duty values are also picked up again at the midpoint, so the two halves can carry different on-times.

Top module: `pwm3_timing_unit`

## Requirements
- R1: During reset, and after reset until the first `period_sync` pulse, every `hi_out` and `lo_out` bit is 0 and `period_sync` is 0.
- R2: With half length P (a value of 0 counts as 1), `period_sync` is high for exactly one cycle every 2·P cycles, and `mid_strobe` is high for exactly one cycle, P cycles after `period_sync`. The two are never high together.
- R3: Take the output cycle i of a period, with i = 0 on the `period_sync` cycle. Its distance from the centre is d = P−1−i in the leading half (i < P) and d = i−P in the trailing half. The high side of a phase with duty D and dead time T is high exactly when d < max(D−T, 0). This gives D−T cycles on each side of the centre.
- R4: The low side is high exactly when d ≥ D+T. The cycles with D−T ≤ d < D+T have both sides low, and `hi_out[k]` and `lo_out[k]` are never high together.
- R5: If D ≤ T, the adjusted on-time is clamped to zero and the high side stays low for the whole half.
- R6: With minimum width M, if max(D−T, 0) < M, then for the whole half the high side is 0 and the low side is 1.
- R7: If R6 does not apply and max(P−D−T, 0) < M, then for the whole half the high side is 1 and the low side is 0.
- R8: `half_len`, `dead_len`, `min_len`, `dbl_mode` and the duty inputs are captured only at a period start. In single-update mode (`dbl_mode`=0), a change to a duty input after the period has started has no effect on either half of that period.
- R9: In double-update mode, the duty inputs present at the midpoint govern the trailing half. The leading half keeps the values captured at the period start.
- R10: Bit 0 of `hi_out`/`lo_out` is phase A (`duty_a`), bit 1 is phase B and bit 2 is phase C. Each phase follows only its own duty input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| dbl_mode | input | 1 | 1 = duty values also reloaded at the midpoint |
| half_len | input | CW | Half-period length P in clocks (full period 2·P) |
| dead_len | input | CW | Dead time T in clocks, applied on each side of every edge |
| min_len | input | CW | Minimum on-time M per half period in clocks |
| duty_a | input | CW | Phase A duty D in clocks per half period |
| duty_b | input | CW | Phase B duty |
| duty_c | input | CW | Phase C duty |
| hi_out | output | 3 | High-side outputs, active high, bit k = phase k |
| lo_out | output | 3 | Low-side outputs, active high |
| period_sync | output | 1 | One-cycle pulse at each period start |
| mid_strobe | output | 1 | One-cycle pulse at each period midpoint |

## Verification
The midpoint reload and the minimum-width suppression can land in the same cycle. This happens when a duty value loaded at the midpoint of a double-update period is narrow enough that the trailing half must be fully suppressed. The bench changes the duty inputs right after `period_sync`. It then checks, from the `mid_strobe` cycle onward, that the suppressed phase switches at once to a full-half low-side level while the other phases follow their new edges. The same change is repeated in single-update mode, where the whole period must keep its old shape.

// File: rtl/pwm3_pkg.sv
package pwm3_pkg;
  localparam int NLEG = 3;

  // LEAD: counter moves towards the period centre; TRAIL: moves away
  typedef enum logic {
    HALF_LEAD  = 1'b0,
    HALF_TRAIL = 1'b1
  } half_e;
endpackage

// File: rtl/pwm3_sweep.sv
module pwm3_sweep
  import pwm3_pkg::*;
#(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] period_in,
  output logic [CW-1:0] cnt,
  output half_e         half,
  output logic [CW-1:0] p_act,
  output logic          run,
  output logic          ld_full,
  output logic          ld_mid
);
  localparam logic [CW-1:0] ONE = CW'(1);

  logic [CW-1:0] cnt_q, cnt_d, p_q, p_d, p_new;
  half_e         half_q, half_d;
  logic          run_q, run_d;
  logic          at_end, at_mid;

  assign p_new  = (period_in == '0) ? ONE : period_in;
  assign at_end = run_q ? (half_q == HALF_TRAIL && cnt_q == p_q - ONE) : 1'b1;
  assign at_mid = run_q && half_q == HALF_LEAD && cnt_q == '0;

  always_comb begin
    cnt_d  = cnt_q;
    half_d = half_q;
    p_d    = p_q;
    run_d  = run_q;
    if (at_end) begin
      cnt_d  = p_new - ONE;
      half_d = HALF_LEAD;
      p_d    = p_new;
      run_d  = 1'b1;
    end else if (at_mid) begin
      cnt_d  = '0;
      half_d = HALF_TRAIL;
    end else if (half_q == HALF_LEAD) begin
      cnt_d  = cnt_q - ONE;
    end else begin
      cnt_d  = cnt_q + ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      half_q <= HALF_TRAIL;
      p_q    <= ONE;
      run_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      half_q <= half_d;
      run_q  <= run_d;
      if (at_end) p_q <= p_d;
    end
  end

  assign cnt     = cnt_q;
  assign half    = half_q;
  assign p_act   = p_q;
  assign run     = run_q;
  assign ld_full = at_end;
  assign ld_mid  = at_mid;

  // R2: the sweep never leaves the programmed half length
  a_r2_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (cnt_q < p_q));
  // R2: a period start and a midpoint never coincide
  a_r2_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !(ld_full && ld_mid));
endmodule

// File: rtl/pwm3_leg.sv
module pwm3_leg #(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          ld_duty,
  input  logic [CW-1:0] duty_in,
  input  logic [CW-1:0] cnt,
  input  logic [CW-1:0] p_act,
  input  logic [CW-1:0] dt_act,
  input  logic [CW-1:0] mp_act,
  output logic          hi,
  output logic          lo
);
  localparam int W = CW + 2;

  logic [CW-1:0] duty_q;
  logic [W-1:0]  d_w, t_w, m_w, p_w, c_w;
  logic [W-1:0]  hi_on, lo_edge, lo_on;
  logic          hi_d, lo_d, hi_q, lo_q;

  assign d_w = {2'b00, duty_q};
  assign t_w = {2'b00, dt_act};
  assign m_w = {2'b00, mp_act};
  assign p_w = {2'b00, p_act};
  assign c_w = {2'b00, cnt};

  always_comb begin
    hi_on   = (d_w > t_w) ? (d_w - t_w) : '0;
    lo_edge = d_w + t_w;
    lo_on   = (p_w > lo_edge) ? (p_w - lo_edge) : '0;
    if (hi_on < m_w) begin
      hi_d = 1'b0;
      lo_d = 1'b1;
    end else if (lo_on < m_w) begin
      hi_d = 1'b1;
      lo_d = 1'b0;
    end else begin
      hi_d = (c_w < hi_on);
      lo_d = (c_w >= lo_edge);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      duty_q <= '0;
      hi_q   <= 1'b0;
      lo_q   <= 1'b0;
    end else begin
      if (ld_duty) duty_q <= duty_in;
      hi_q <= run & hi_d;
      lo_q <= run & lo_d;
    end
  end

  assign hi = hi_q;
  assign lo = lo_q;

  // R4: both switches of one pair are never driven on together
  a_r4_pair_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(hi_q && lo_q));
endmodule

// File: rtl/pwm3_timing_unit.sv
module pwm3_timing_unit
  import pwm3_pkg::*;
#(
  parameter int CW = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            dbl_mode,
  input  logic [CW-1:0]   half_len,
  input  logic [CW-1:0]   dead_len,
  input  logic [CW-1:0]   min_len,
  input  logic [CW-1:0]   duty_a,
  input  logic [CW-1:0]   duty_b,
  input  logic [CW-1:0]   duty_c,
  output logic [NLEG-1:0] hi_out,
  output logic [NLEG-1:0] lo_out,
  output logic            period_sync,
  output logic            mid_strobe
);
  logic          rst_meta, rst_sync;
  logic [CW-1:0] cnt, p_act;
  half_e         half;
  logic          run, ld_full, ld_mid, ld_duty;
  logic [CW-1:0] dt_q, mp_q;
  logic          dbl_q, sync_q, mid_q, sync_d, mid_d;
  logic [CW-1:0] duty_arr [NLEG];

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  pwm3_sweep #(.CW(CW)) u_sweep (
    .clk      (clk),
    .rst_n    (rst_sync),
    .period_in(half_len),
    .cnt      (cnt),
    .half     (half),
    .p_act    (p_act),
    .run      (run),
    .ld_full  (ld_full),
    .ld_mid   (ld_mid)
  );

  assign ld_duty = ld_full | (ld_mid & dbl_q);
  assign sync_d  = run && half == HALF_LEAD  && cnt == p_act - CW'(1);
  assign mid_d   = run && half == HALF_TRAIL && cnt == '0;

  always_ff @(posedge clk or negedge rst_sync) begin
    if (!rst_sync) begin
      dt_q   <= '0;
      mp_q   <= '0;
      dbl_q  <= 1'b0;
      sync_q <= 1'b0;
      mid_q  <= 1'b0;
    end else begin
      if (ld_full) begin
        dt_q  <= dead_len;
        mp_q  <= min_len;
        dbl_q <= dbl_mode;
      end
      sync_q <= sync_d;
      mid_q  <= mid_d;
    end
  end

  assign duty_arr[0] = duty_a;
  assign duty_arr[1] = duty_b;
  assign duty_arr[2] = duty_c;

  for (genvar k = 0; k < NLEG; k++) begin : g_leg
    pwm3_leg #(.CW(CW)) u_leg (
      .clk    (clk),
      .rst_n  (rst_sync),
      .run    (run),
      .ld_duty(ld_duty),
      .duty_in(duty_arr[k]),
      .cnt    (cnt),
      .p_act  (p_act),
      .dt_act (dt_q),
      .mp_act (mp_q),
      .hi     (hi_out[k]),
      .lo     (lo_out[k])
    );
  end

  assign period_sync = sync_q;
  assign mid_strobe  = mid_q;

  // R2: the sync pulse is a single cycle wide
  a_r2_sync_single: assert property (@(posedge clk) disable iff (!rst_sync)
    period_sync |=> !period_sync);
  // R2: sync and midpoint strobe are never high together
  a_r2_sync_mid_apart: assert property (@(posedge clk) disable iff (!rst_sync)
    !(period_sync && mid_strobe));
  // R1: outputs stay quiet until the sweep is running
  a_r1_idle_until_run: assert property (@(posedge clk) disable iff (!rst_sync)
    !run |=> (hi_out == '0 && lo_out == '0 && !period_sync && !mid_strobe));
endmodule

// File: tb/tb_pwm3_timing_unit.sv
module tb_pwm3_timing_unit;
  localparam int CW = 12;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          dbl_mode;
  logic [CW-1:0] half_len, dead_len, min_len, duty_a, duty_b, duty_c;
  logic [2:0]    hi_out, lo_out;
  logic          period_sync, mid_strobe;

  always #4 clk = ~clk;

  pwm3_timing_unit #(.CW(CW)) dut (
    .clk(clk), .rst_n(rst_n), .dbl_mode(dbl_mode),
    .half_len(half_len), .dead_len(dead_len), .min_len(min_len),
    .duty_a(duty_a), .duty_b(duty_b), .duty_c(duty_c),
    .hi_out(hi_out), .lo_out(lo_out),
    .period_sync(period_sync), .mid_strobe(mid_strobe)
  );

  typedef struct packed {
    logic [2:0] hi;
    logic [2:0] lo;
    logic       sy;
    logic       md;
  } obs_t;

  int    n_chk = 0;
  int    n_err = 0;
  obs_t  exp_q[$];
  string tag_q[$];
  int    idx_q[$];

  function automatic obs_t sample();
    obs_t o;
    o.hi = hi_out;
    o.lo = lo_out;
    o.sy = period_sync;
    o.md = mid_strobe;
    return o;
  endfunction

  task automatic compare(obs_t got, obs_t exp, string tag, int idx);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s cycle %0d: got hi=%b lo=%b sync=%b mid=%b expected hi=%b lo=%b sync=%b mid=%b",
               tag, idx, got.hi, got.lo, got.sy, got.md, exp.hi, exp.lo, exp.sy, exp.md);
    end
  endtask

  // {hi,lo} for one phase at centre distance d (R3..R7)
  function automatic logic [1:0] leg_exp(int d, int p, int dd, int t, int m);
    int hon, edg, lon;
    hon = (dd > t) ? dd - t : 0;
    edg = dd + t;
    lon = (p > edg) ? p - edg : 0;
    if (hon < m) return 2'b01;
    if (lon < m) return 2'b10;
    return {logic'(d < hon), logic'(d >= edg)};
  endfunction

  function automatic obs_t item_exp(int i, int p, int t, int m, bit dbl,
                                    int a1, int b1, int c1, int a2, int b2, int c2);
    obs_t o;
    int d, da, db, dc;
    logic [1:0] ra, rb, rc;
    bit trail;
    trail = (i >= p);
    d  = trail ? i - p : p - 1 - i;
    da = (trail && dbl) ? a2 : a1;
    db = (trail && dbl) ? b2 : b1;
    dc = (trail && dbl) ? c2 : c1;
    ra = leg_exp(d, p, da, t, m);
    rb = leg_exp(d, p, db, t, m);
    rc = leg_exp(d, p, dc, t, m);
    o.hi = {rc[1], rb[1], ra[1]};
    o.lo = {rc[0], rb[0], ra[0]};
    o.sy = (i == 0);
    o.md = (i == p);
    return o;
  endfunction

  task automatic report();
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: run did not complete");
    report();
    $finish;
  end

  // monitor: pops one expected item per cycle
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (exp_q.size() > 0) compare(sample(), exp_q.pop_front(), tag_q.pop_front(), idx_q.pop_front());
    end
  end

  task automatic wait_sync(string tag);
    int t;
    t = 0;
    do begin
      @(negedge clk);
      t++;
    end while (!period_sync && t < 600);
    if (!period_sync) begin
      n_chk++;
      n_err++;
      $display("FAIL %s: no period_sync seen, got 0 expected 1", tag);
    end
  endtask

  // driver: programs a case, captures one full period into the scoreboard
  task automatic run_case(string tag, int p, int t, int m, bit dbl,
                          int a1, int b1, int c1, int a2, int b2, int c2);
    half_len = CW'(p);
    dead_len = CW'(t);
    min_len  = CW'(m);
    dbl_mode = dbl;
    duty_a   = CW'(a1);
    duty_b   = CW'(b1);
    duty_c   = CW'(c1);
    wait_sync(tag);
    wait_sync(tag);
    compare(sample(), item_exp(0, p, t, m, dbl, a1, b1, c1, a2, b2, c2), tag, 0);
    // change after the period start: R8 ignores it, R9 uses it at the midpoint
    duty_a = CW'(a2);
    duty_b = CW'(b2);
    duty_c = CW'(c2);
    for (int i = 1; i < 2 * p; i++) begin
      exp_q.push_back(item_exp(i, p, t, m, dbl, a1, b1, c1, a2, b2, c2));
      tag_q.push_back(tag);
      idx_q.push_back(i);
    end
    while (exp_q.size() > 0) @(negedge clk);
  endtask

  initial begin
    rst_n    = 1'b0;
    dbl_mode = 1'b0;
    half_len = CW'(20);
    dead_len = CW'(2);
    min_len  = '0;
    duty_a   = CW'(10);
    duty_b   = CW'(5);
    duty_c   = CW'(15);

    // R1: quiet during reset
    repeat (3) begin
      @(negedge clk);
      compare(sample(), '0, "R1 in reset", 0);
    end
    rst_n = 1'b1;
    // R1: quiet after release until the first sync
    begin
      int t;
      t = 0;
      @(negedge clk);
      while (!period_sync && t < 50) begin
        compare(sample(), '0, "R1 before first sync", t);
        @(negedge clk);
        t++;
      end
    end

    // R2 R3 R4 R10: three different duties, plain edges
    run_case("R2 R3 R4 R10 basic", 20, 2, 0, 1'b0, 10, 5, 15, 10, 5, 15);
    // R5: duty at or below dead time clamps the high side
    run_case("R5 clamp", 16, 3, 0, 1'b0, 2, 3, 0, 2, 3, 0);
    // R6: phase A adjusted on-time 2 is below the minimum 4
    run_case("R6 high narrow", 20, 3, 4, 1'b0, 5, 12, 8, 5, 12, 8);
    // R7: phase A low side too narrow, phase C high side too narrow
    run_case("R7 low narrow", 20, 2, 3, 1'b0, 17, 10, 3, 17, 10, 3);
    // R8: new duties presented mid-period are ignored in single-update mode
    run_case("R8 single update", 20, 2, 3, 1'b0, 9, 8, 10, 4, 14, 18);
    // R9: same change applies at the midpoint; phase A suppressed there (R6),
    // phase C forced fully high in the trailing half (R7)
    run_case("R9 double update", 20, 2, 3, 1'b1, 9, 8, 10, 4, 14, 18);
    // R2: shortest half length
    run_case("R2 unit half", 1, 0, 0, 1'b0, 1, 0, 1, 1, 0, 1);

    // R2: sync spacing is 2*P cycles
    begin
      int gap;
      obs_t g, e;
      half_len = CW'(7);
      wait_sync("R2 spacing");
      wait_sync("R2 spacing");
      gap = 0;
      do begin
        @(negedge clk);
        gap++;
      end while (!period_sync && gap < 100);
      g = '0; e = '0;
      g.hi = 3'(gap);
      e.hi = 3'(14);
      n_chk++;
      if (gap != 14) begin
        n_err++;
        $display("FAIL R2 spacing: got %0d cycles expected %0d", gap, 14);
      end
    end

    report();
    $finish;
  end
endmodule